// File: doc/BRIEF.md
# Parallel Converter Bus Sequencer

This block sits on the host side of a two-channel, 16-bit parallel digital-to-analog converter. It takes one command at a time on a valid/ready handshake. A command can write a channel's input register, read a channel's input register back, copy both input registers to the converter outputs together, or pulse the converter's reset. For each command it drives the converter pins in order: chip select, the read/write level, the channel select, the load strobe, the reset line, and the bidirectional data bus, given here as separate out, enable and in lines.

Every pin phase has a minimum length given in nanoseconds. Each one is turned into clock cycles by rounding up against the clock-period parameter, and no phase is shorter than one cycle. A read waits out the converter's access time, samples the bus in the last cycle of the select window, and returns the word with a one-cycle valid pulse. After a read, the host keeps its bus drivers off until the converter has had time to release the bus. After a load, the block can also stay busy until the analog outputs have settled.

Top module: `dacbus_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, the outputs sit at idle: `bus_cs_n`=1, `bus_rd`=1, `bus_ld`=0, `bus_rst_n`=1, `bus_oe`=0, `rd_valid`=0, `cmd_ready`=1. A reset in the middle of a sequence ends that sequence at once.
- R2: A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_op` encodes the command as 0 = write, 1 = read, 2 = load, 3 = reset, and `cmd_chan` selects channel 0 or 1. `cmd_ready` is low from the cycle after acceptance until the sequence ends. Any `cmd_valid` seen while busy has no effect.
- R3: A write holds `bus_rd`=0 with the data driven (`bus_oe`=1) for one setup cycle. Chip select is then low for ceil(40 ns / T) cycles, and a hold of ceil(10 ns / T) cycles with chip select high follows. At 8 ns the block is busy for 8 cycles. A write does not change the converter outputs.
- R4: A read keeps `bus_oe`=0. `bus_rd` is high for at least ceil(10 ns / T) cycles before chip select falls. Chip select stays low for ceil(max(150 ns, 150 ns access) / T) cycles, which is 19 at 8 ns.
- R5: Read data is sampled in the last low cycle of chip select. It is presented on `rd_data` with `rd_valid` high for exactly one cycle, the first cycle after chip select rises, and `rd_data` keeps that value afterwards.
- R6: `bus_oe` is never high while chip select is low with `bus_rd` high. After a read, the block stays busy for max(hold, 100 ns release) cycles after chip select rises, so a read occupies 34 cycles at 8 ns.
- R7: A load keeps chip select high throughout. It waits ceil(30 ns / T) cycles, drives `bus_ld` high for ceil(100 ns / T) cycles, and then keeps it low for ceil(100 ns / T) cycles before the sequence can end. The converter outputs then hold the input registers of both channels.
- R8: With `SETTLE_EN` set, a load then stays busy for a further ceil(10 us / T) cycles, so a whole load lasts 1280 cycles at 8 ns.
- R9: A reset command drives `bus_rst_n` low for ceil(10 ns / T) cycles and then high for the same count, with chip select high. It takes 4 cycles at 8 ns and clears the converter's input and output registers to zero.
- R10: `bus_sel`, `bus_rd` and `bus_dout` are set before chip select falls and do not change while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| cmd_op | input | 2 | 0 write, 1 read, 2 load, 3 reset |
| cmd_chan | input | 1 | Channel index for write and read |
| cmd_data | input | DATA_W | Word to write |
| rd_valid | output | 1 | One-cycle pulse marking a new read word |
| rd_data | output | DATA_W | Last word read back |
| bus_cs_n | output | 1 | Converter chip select, active low |
| bus_rd | output | 1 | 1 = read access, 0 = write access |
| bus_sel | output | 1 | Converter channel select |
| bus_ld | output | 1 | Load strobe; its rising edge updates the outputs |
| bus_rst_n | output | 1 | Converter reset; acts on its rising edge |
| bus_dout | output | DATA_W | Data the host drives onto the bus |
| bus_oe | output | 1 | Host bus driver enable |
| bus_din | input | DATA_W | Data the converter returns on the bus |

## Verification
The assertions assume that `cmd_op` always holds one of the four codes and that the command fields are valid on the cycle the command is accepted. They also assume that `bus_din` carries the converter's word only in the final cycle of a read select window. The stimulus raises `cmd_valid` only away from the clock edge and keeps the fields steady until acceptance. It briefly asserts a request during a busy sequence to show that it is ignored. The converter model returns a marker value until the access time has passed, so a sample taken too early shows up as a wrong word.

// File: rtl/dacbus_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the converter bus sequencer.
// Assumes all timing values are non-negative nanosecond integers.
package dacbus_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_RESET = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WLOW,
        PH_WHOLD,
        PH_RSETUP,
        PH_RLOW,
        PH_RFLOAT,
        PH_LGAP,
        PH_LHIGH,
        PH_LLOW,
        PH_SETTLE,
        PH_XLOW,
        PH_XHIGH
    } phase_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacbus_timer.sv
`timescale 1ns/1ps
// Phase length down-counter. A load sets the remaining count; the
// counter then decrements and stops at zero, where expired is high.
// Assumes the caller loads (length - 1) on the first cycle of a phase.
module dacbus_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down toward zero, reloading at each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // Once expired, the counter stays expired until reloaded.
    assert_timer_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/dacbus_rdcap.sv
`timescale 1ns/1ps
// Read-back capture: stores the bus word when told to sample and
// flags it with a single-cycle valid. The word stays until the next sample.
// Assumes sample is high for at most one cycle per read.
module dacbus_rdcap #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic [W-1:0] din,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);
    // Hold the sampled word and raise valid on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample)
                rd_data <= din;
        end
    end

    // The stored word changes only through a sample.
    assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample) |-> $stable(rd_data));

endmodule

// File: rtl/dacbus_seq.sv
`timescale 1ns/1ps
// Host-side sequencer for a two-channel parallel converter bus.
// Takes one command at a time and drives the converter pins through
// timed phases, each derived from a nanosecond limit and CLK_NS.
// Assumes cmd_op holds a legal code and cmd fields are valid on acceptance.
module dacbus_seq
    import dacbus_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CLK_NS      = 8,
    parameter int T_WSETUP_NS = 0,
    parameter int T_WLOW_NS   = 40,
    parameter int T_RSETUP_NS = 10,
    parameter int T_RLOW_NS   = 150,
    parameter int T_ACCESS_NS = 150,
    parameter int T_HOLD_NS   = 10,
    parameter int T_FLOAT_NS  = 100,
    parameter int T_LGAP_NS   = 30,
    parameter int T_LHIGH_NS  = 100,
    parameter int T_LLOW_NS   = 100,
    parameter int T_LSEP_NS   = 100,
    parameter int T_XLOW_NS   = 10,
    parameter int T_XHIGH_NS  = 10,
    parameter int T_SETTLE_NS = 10000,
    parameter bit SETTLE_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_chan,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_cs_n,
    output logic              bus_rd,
    output logic              bus_sel,
    output logic              bus_ld,
    output logic              bus_rst_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din
);
    localparam int unsigned C_WSETUP = ns2cyc(T_WSETUP_NS, CLK_NS);
    localparam int unsigned C_WLOW   = ns2cyc(T_WLOW_NS, CLK_NS);
    localparam int unsigned C_HOLD   = ns2cyc(T_HOLD_NS, CLK_NS);
    localparam int unsigned C_RSETUP = ns2cyc(T_RSETUP_NS, CLK_NS);
    localparam int unsigned C_RLOW   = ns2cyc(umax(T_RLOW_NS, T_ACCESS_NS), CLK_NS);
    localparam int unsigned C_RFLOAT = umax(C_HOLD, ns2cyc(T_FLOAT_NS, CLK_NS));
    localparam int unsigned C_LGAP   = ns2cyc(T_LGAP_NS, CLK_NS);
    localparam int unsigned C_LHIGH  = ns2cyc(T_LHIGH_NS, CLK_NS);
    localparam int unsigned C_LLOW   = ns2cyc(umax(T_LLOW_NS, T_LSEP_NS), CLK_NS);
    localparam int unsigned C_SETTLE = ns2cyc(T_SETTLE_NS, CLK_NS);
    localparam int unsigned C_XLOW   = ns2cyc(T_XLOW_NS, CLK_NS);
    localparam int unsigned C_XHIGH  = ns2cyc(T_XHIGH_NS, CLK_NS);
    localparam int unsigned C_MAX    =
        umax(umax(umax(C_WSETUP, C_WLOW), umax(C_HOLD, C_RSETUP)),
             umax(umax(umax(C_RLOW, C_RFLOAT), umax(C_LGAP, C_LHIGH)),
                  umax(umax(C_LLOW, C_SETTLE), umax(C_XLOW, C_XHIGH))));
    localparam int CNT_W = $clog2(C_MAX + 1);

    phase_e            ph_q, ph_d;
    logic              chan_q;
    logic [DATA_W-1:0] wdata_q;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic              rd_sample;

    // Remaining-count value to load on entry to a phase.
    function automatic logic [CNT_W-1:0] plen_m1(phase_e p);
        case (p)
            PH_WSETUP: return CNT_W'(C_WSETUP - 1);
            PH_WLOW:   return CNT_W'(C_WLOW - 1);
            PH_WHOLD:  return CNT_W'(C_HOLD - 1);
            PH_RSETUP: return CNT_W'(C_RSETUP - 1);
            PH_RLOW:   return CNT_W'(C_RLOW - 1);
            PH_RFLOAT: return CNT_W'(C_RFLOAT - 1);
            PH_LGAP:   return CNT_W'(C_LGAP - 1);
            PH_LHIGH:  return CNT_W'(C_LHIGH - 1);
            PH_LLOW:   return CNT_W'(C_LLOW - 1);
            PH_SETTLE: return CNT_W'(C_SETTLE - 1);
            PH_XLOW:   return CNT_W'(C_XLOW - 1);
            PH_XHIGH:  return CNT_W'(C_XHIGH - 1);
            default:   return '0;
        endcase
    endfunction

    // Next phase: leave idle on a command, otherwise advance when the timer expires.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_WRITE: ph_d = PH_WSETUP;
                        OP_READ:  ph_d = PH_RSETUP;
                        OP_LOAD:  ph_d = PH_LGAP;
                        default:  ph_d = PH_XLOW;
                    endcase
                end
            end
            PH_WSETUP: if (tmr_exp) ph_d = PH_WLOW;
            PH_WLOW:   if (tmr_exp) ph_d = PH_WHOLD;
            PH_WHOLD:  if (tmr_exp) ph_d = PH_IDLE;
            PH_RSETUP: if (tmr_exp) ph_d = PH_RLOW;
            PH_RLOW:   if (tmr_exp) ph_d = PH_RFLOAT;
            PH_RFLOAT: if (tmr_exp) ph_d = PH_IDLE;
            PH_LGAP:   if (tmr_exp) ph_d = PH_LHIGH;
            PH_LHIGH:  if (tmr_exp) ph_d = PH_LLOW;
            PH_LLOW:   if (tmr_exp) ph_d = SETTLE_EN ? PH_SETTLE : PH_IDLE;
            PH_SETTLE: if (tmr_exp) ph_d = PH_IDLE;
            PH_XLOW:   if (tmr_exp) ph_d = PH_XHIGH;
            PH_XHIGH:  if (tmr_exp) ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    assign tmr_load  = (ph_d != ph_q);
    assign tmr_val   = plen_m1(ph_d);
    assign cmd_ready = (ph_q == PH_IDLE);
    assign rd_sample = (ph_q == PH_RLOW) && tmr_exp;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= PH_IDLE;
        else
            ph_q <= ph_d;
    end

    // Latch the command operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= 1'b0;
            wdata_q <= '0;
        end else if (cmd_ready && cmd_valid) begin
            chan_q  <= cmd_chan;
            wdata_q <= cmd_data;
        end
    end

    // Pin outputs registered from the next phase, so they are glitch-free and aligned with ph_q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_cs_n  <= 1'b1;
            bus_rd    <= 1'b1;
            bus_oe    <= 1'b0;
            bus_ld    <= 1'b0;
            bus_rst_n <= 1'b1;
        end else begin
            bus_cs_n  <= !(ph_d == PH_WLOW || ph_d == PH_RLOW);
            bus_rd    <= !(ph_d inside {PH_WSETUP, PH_WLOW, PH_WHOLD});
            bus_oe    <= (ph_d inside {PH_WSETUP, PH_WLOW, PH_WHOLD});
            bus_ld    <= (ph_d == PH_LHIGH);
            bus_rst_n <= (ph_d != PH_XLOW);
        end
    end

    assign bus_sel  = chan_q;
    assign bus_dout = wdata_q;

    dacbus_timer #(.W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dacbus_rdcap #(.W(DATA_W)) rdcap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rd_sample),
        .din      (bus_din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_rd) |-> !bus_oe);

    assert_ld_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ld |-> bus_cs_n);

    assert_rdvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rst_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> (bus_cs_n && !bus_ld));

    assert_stable_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |-> ($stable(bus_sel) && $stable(bus_rd) && $stable(bus_dout)));

endmodule

// File: tb/dacbus_seq_tb.sv
`timescale 1ns/1ps
module dacbus_seq_tb_top;
    localparam int DW = 16;
    localparam int CK = 8;

    function automatic int cyc(int ns);
        int c;
        c = (ns + CK - 1) / CK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_WLOW   = cyc(40);
    localparam int E_RLOW   = cyc(150);
    localparam int E_RSETUP = cyc(10);
    localparam int E_LHIGH  = cyc(100);
    localparam int E_XLOW   = cyc(10);
    localparam int E_WBUSY  = 1 + E_WLOW + cyc(10);
    localparam int E_RBUSY  = E_RSETUP + E_RLOW + cyc(100);
    localparam int E_LBUSY  = cyc(30) + E_LHIGH + cyc(100) + cyc(10000);
    localparam int E_XBUSY  = 2 * E_XLOW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_chan = 1'b0;
    logic [DW-1:0] cmd_data = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          bus_cs_n, bus_rd, bus_sel, bus_ld, bus_rst_n, bus_oe;
    logic [DW-1:0] bus_dout, bus_din;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CK/2) clk = ~clk;

    dacbus_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_cs_n(bus_cs_n), .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_ld(bus_ld),
        .bus_rst_n(bus_rst_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter model: input registers, output registers, access delay.
    logic [DW-1:0] mreg [2];
    logic [DW-1:0] mout [2];
    int acc = 0;
    initial begin
        mreg[0] = '0; mreg[1] = '0; mout[0] = '0; mout[1] = '0;
    end
    always @(posedge bus_cs_n)
        if (bus_rd === 1'b0 && bus_oe === 1'b1) mreg[bus_sel] <= bus_dout;
    always @(posedge bus_ld) begin
        mout[0] <= mreg[0];
        mout[1] <= mreg[1];
    end
    always @(posedge bus_rst_n) begin
        mreg[0] <= '0; mreg[1] <= '0; mout[0] <= '0; mout[1] <= '0;
    end
    always @(posedge clk) acc <= (bus_cs_n === 1'b0) ? acc + 1 : 0;
    assign bus_din = (bus_cs_n === 1'b0 && bus_rd === 1'b1 && acc >= E_RLOW - 1)
                     ? mreg[bus_sel] : 16'hDEAD;

    // Pin timing monitor, sampled between edges.
    int  lowcnt = 0, ldcnt = 0, xcnt = 0, rdrun = 0;
    bit  prev_cs = 1, prev_rd = 1, prev_ld = 0, prev_x = 1;
    bit  clash = 0, ldclash = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            lowcnt = 0; ldcnt = 0; xcnt = 0; rdrun = 0;
            prev_cs = 1; prev_rd = 1; prev_ld = 0; prev_x = 1;
        end else begin
            if (!bus_cs_n && bus_rd && bus_oe) clash = 1;
            if (bus_ld && !bus_cs_n) ldclash = 1;
            if (!bus_cs_n) begin
                if (prev_cs) begin
                    chk(bus_rd == prev_rd, "R10 access type set before select", bus_rd, prev_rd);
                    if (bus_rd) chk(rdrun >= E_RSETUP, "R4 read level setup", rdrun, E_RSETUP);
                    lowcnt = 0;
                end
                lowcnt++;
            end else begin
                if (!prev_cs)
                    chk(lowcnt == (prev_rd ? E_RLOW : E_WLOW),
                        prev_rd ? "R4 read select width" : "R3 write select width",
                        lowcnt, prev_rd ? E_RLOW : E_WLOW);
                rdrun = bus_rd ? rdrun + 1 : 0;
            end
            if (bus_ld) ldcnt++;
            else if (prev_ld) begin
                chk(ldcnt == E_LHIGH, "R7 load strobe width", ldcnt, E_LHIGH);
                ldcnt = 0;
            end
            if (!bus_rst_n) xcnt++;
            else if (!prev_x) begin
                chk(xcnt == E_XLOW, "R9 reset pulse width", xcnt, E_XLOW);
                xcnt = 0;
            end
            prev_cs = bus_cs_n; prev_rd = bus_rd; prev_ld = bus_ld; prev_x = bus_rst_n;
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic ch, input logic [DW-1:0] d,
                           output int busy, output logic [DW-1:0] rdv, output bit got);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy = 0; got = 0; rdv = '0;
        while (!cmd_ready) begin
            busy++;
            if (rd_valid) begin got = 1; rdv = rd_data; end
            @(negedge clk);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(bus_cs_n == 1 && bus_rd == 1 && bus_ld == 0 && bus_rst_n == 1 &&
            bus_oe == 0 && rd_valid == 0 && cmd_ready == 1, tag,
            {bus_cs_n, bus_rd, bus_ld, bus_rst_n, bus_oe, rd_valid, cmd_ready}, 7'b1101001);
    endtask

    // op, chan, data, expected A (read word or output A), expected B (output B)
    localparam int NV = 10;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'h1234, 16'h0000, 16'h0000},
        {2'd0, 1'b1, 16'hABCD, 16'h0000, 16'h0000},
        {2'd1, 1'b0, 16'h0000, 16'h1234, 16'h0000},
        {2'd1, 1'b1, 16'h0000, 16'hABCD, 16'h0000},
        {2'd2, 1'b0, 16'h0000, 16'h1234, 16'hABCD},
        {2'd0, 1'b0, 16'hFFFF, 16'h1234, 16'hABCD},
        {2'd1, 1'b0, 16'h0000, 16'hFFFF, 16'h0000},
        {2'd2, 1'b0, 16'h0000, 16'hFFFF, 16'hABCD},
        {2'd3, 1'b0, 16'h0000, 16'h0000, 16'h0000},
        {2'd1, 1'b1, 16'h0000, 16'h0000, 16'h0000}
    };

    initial begin
        int busy;
        logic [DW-1:0] rdv;
        bit got;
        logic [DW-1:0] last;

        repeat (3) @(negedge clk);
        chk_idle("R1 idle outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle outputs after reset");

        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            v = VEC[i];
            run_cmd(v[50:49], v[48], v[47:32], busy, rdv, got);
            case (v[50:49])
                2'd0: begin
                    chk(busy == E_WBUSY, "R3 write duration", busy, E_WBUSY);
                    chk(mout[0] == v[31:16] && mout[1] == v[15:0], "R3 write leaves outputs",
                        {mout[0], mout[1]}, v[31:0]);
                end
                2'd1: begin
                    chk(busy == E_RBUSY, "R6 read duration", busy, E_RBUSY);
                    chk(got && rdv == v[31:16], "R5 read word", {15'd0, got, rdv}, {16'd1, v[31:16]});
                end
                2'd2: begin
                    chk(busy == E_LBUSY, "R8 load with settle duration", busy, E_LBUSY);
                    chk(mout[0] == v[31:16] && mout[1] == v[15:0], "R7 load outputs",
                        {mout[0], mout[1]}, v[31:0]);
                end
                default: begin
                    chk(busy == E_XBUSY, "R9 reset duration", busy, E_XBUSY);
                    chk(mout[0] == 0 && mout[1] == 0, "R9 outputs cleared",
                        {mout[0], mout[1]}, 32'd0);
                end
            endcase
        end

        // R5: the read word persists after the valid pulse.
        run_cmd(2'd0, 1'b1, 16'h5A5A, busy, rdv, got);
        run_cmd(2'd1, 1'b1, 16'h0000, busy, rdv, got);
        last = rdv;
        repeat (5) @(negedge clk);
        chk(rd_data == 16'h5A5A && last == 16'h5A5A && !rd_valid, "R5 read word held",
            rd_data, 16'h5A5A);

        // R2: a request raised while busy is ignored.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_chan = 1'b1; cmd_data = 16'h0F0F;
        @(negedge clk);
        cmd_op = 2'd3; cmd_data = 16'h1111;
        repeat (2) @(negedge clk);
        chk(!cmd_ready, "R2 busy after accept", cmd_ready, 0);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        run_cmd(2'd1, 1'b1, 16'h0000, busy, rdv, got);
        chk(rdv == 16'h0F0F, "R2 busy request ignored", rdv, 16'h0F0F);

        // R1: reset in the middle of a load.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(bus_ld == 1'b1, "R7 strobe active before abort", bus_ld, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after mid-sequence reset");

        chk(!clash, "R6 no bus contention", clash, 0);
        chk(!ldclash, "R7 select high during load", ldclash, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule